// File: doc/BRIEF.md
# Synchronous Serial Shift Engine

This block is the byte-shifting core of a small serial port. It holds one 8-bit shift register that the CPU bus writes and reads directly, a sample latch, a 4-bit edge counter, and a buffer that keeps a copy of the last completed byte. Software chooses between a three-wire link with a push-pull data-out pin and a two-wire link with open-drain data and clock lines. In either case the port can be the clock master or a slave. Every shift-clock edge advances the counter. After 16 edges, which is one byte, the counter wraps and raises an overflow flag.

The shift clock comes from one of three sources: a software strobe where each pulse is one edge, a timer compare-match pulse, or edges seen on the external clock pin. For the first two sources the block keeps its own clock level and drives it out as the master clock. In two-wire mode the block also detects a start condition (data falling while the clock is high). While the start flag or the overflow flag is pending, it stretches the clock by holding SCL low. Addressing, acknowledge, baud generation and multi-byte framing are left to software.

The bus side is a plain register interface: a write strobe loads the register in the same cycle and the read port always shows it, so there is no back-pressure. Serial data has no flow control other than the two-wire clock hold. There is no receive buffering beyond the buffer copy, and a new transfer overwrites the shift register in place.

Top module: `syncser_engine`

## Requirements
- R1: After reset the shift register, buffer, counter, both flags, the internal clock level, `do_out`, `sck_out`, `sda_oe` and `scl_oe` are all 0.
- R2: A cycle with `wr_data_en` high loads `wr_data` into the shift register, and `rd_data` shows it on the next cycle. The write wins over a shift in the same cycle.
- R3: Each shift-clock edge increments the counter by one. The edge taken when the counter is 15 wraps it to 0 and sets `flag_ovf`, which stays set until a `clr_ovf` pulse. If a set and a clear arrive in the same cycle, the set wins. A `wr_cnt_en` cycle loads `wr_cnt` instead of counting.
- R4: A rising shift edge captures the input bit: the synchronised `di_in` in three-wire mode, or the synchronised SDA in two-wire mode. A falling edge shifts the register left and puts the captured bit into bit 0. Data leaves and arrives MSB first.
- R5: Output steering: in three-wire mode (`cfg_wire_mode`=1) `do_out` equals register bit 7 and `sda_oe` is 0. In two-wire mode (`cfg_wire_mode`=2) `sda_oe` is the inverse of bit 7 and `do_out` is 0. When off (0 or 3), both are 0.
- R6: Clock source (`cfg_clk_src`): 0 means only `soft_strobe` pulses count, 1 means only `tmr_match` pulses count, and 2 means only edges of the clock pin count (`sck_in` in three-wire mode, SDA's partner `scl_in` in two-wire mode). Pulses from a source that is not selected are ignored.
- R7: With the wire mode off, no edge is counted, nothing shifts and no flag is set.
- R8: When the counter wraps, the buffer takes the completed byte. It keeps that byte through later writes and shifts until the next wrap.
- R9: Only in two-wire mode, SDA falling while SCL is high sets `flag_start`, which stays set until `clr_start`.
- R10: In two-wire mode, while `flag_start` or `flag_ovf` is pending, `scl_oe` is asserted once SCL has been seen low. It is released the cycle after both flags are clear. It is never asserted while SCL is still high from a fresh start.
- R11: With source 0 or 1, every counted edge toggles an internal clock level. In three-wire master mode `sck_out` follows that level. In two-wire master mode `scl_oe` is asserted while the level is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wire_mode | input | 2 | 0 off, 1 three-wire, 2 two-wire, 3 off |
| cfg_clk_src | input | 2 | 0 software strobe, 1 timer match, 2 clock pin, 3 none |
| cfg_master | input | 1 | Drive the clock from the internal level |
| wr_data_en | input | 1 | Shift register write strobe |
| wr_data | input | 8 | Shift register write value |
| rd_data | output | 8 | Shift register contents |
| buf_data | output | 8 | Last completed byte |
| wr_cnt_en | input | 1 | Counter write strobe |
| wr_cnt | input | 4 | Counter write value |
| cnt_out | output | 4 | Edge counter value |
| soft_strobe | input | 1 | One pulse produces one shift-clock edge |
| tmr_match | input | 1 | Timer compare-match pulse |
| clr_start | input | 1 | Clears the start flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| flag_start | output | 1 | Start condition seen (interrupt request) |
| flag_ovf | output | 1 | Counter wrapped (interrupt request) |
| sck_in | input | 1 | Three-wire clock pin input |
| sck_out | output | 1 | Three-wire master clock output |
| di_in | input | 1 | Three-wire data input |
| do_out | output | 1 | Three-wire data output |
| scl_in | input | 1 | Two-wire clock line level |
| scl_oe | output | 1 | Pull the two-wire clock line low |
| sda_in | input | 1 | Two-wire data line level |
| sda_oe | output | 1 | Pull the two-wire data line low |

## Verification
The assertions check the per-cycle invariants on every cycle. These are the counter stepping, holding and wrapping into the overflow flag; a left shift on every falling edge; the buffer changing only on a wrap; a write taking effect; the internal clock level toggling only on counted edges; and the clock hold and start flag appearing only with their causes. The push-pull and open-drain data outputs are also never active together, and the counter stays put while the port is off. Only the bench scenarios can show the end-to-end results: a complete byte exchanged MSB first over both wire modes, each clock source accepted while the other two are ignored, a start detected or ignored depending on mode, and SCL actually stretched on a modelled open-drain bus and released when the flags are cleared.

// File: rtl/syncser_pkg.sv
package syncser_pkg;
  typedef enum logic [1:0] {
    WM_OFF   = 2'd0,
    WM_THREE = 2'd1,
    WM_TWO   = 2'd2
  } wire_mode_e;

  typedef enum logic [1:0] {
    CS_SOFT  = 2'd0,
    CS_TIMER = 2'd1,
    CS_PIN   = 2'd2
  } clk_src_e;
endpackage

// File: rtl/syncser_sync.sv
module syncser_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/syncser_clkgen.sv
module syncser_clkgen
  import syncser_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     mode_on,
  input  logic     is_two,
  input  clk_src_e src,
  input  logic     soft_stb,
  input  logic     tmr_stb,
  input  logic     sck_s,
  input  logic     scl_s,
  output logic     edge_rise,
  output logic     edge_fall,
  output logic     clk_lvl
);
  logic pin_s, pin_q, int_evt, pin_rise, pin_fall, use_pin;

  assign pin_s    = is_two ? scl_s : sck_s;
  assign pin_rise = pin_s & ~pin_q;
  assign pin_fall = ~pin_s & pin_q;
  assign use_pin  = (src == CS_PIN);
  assign int_evt  = ((src == CS_SOFT) & soft_stb) | ((src == CS_TIMER) & tmr_stb);

  assign edge_rise = mode_on & (use_pin ? pin_rise : (int_evt & ~clk_lvl));
  assign edge_fall = mode_on & (use_pin ? pin_fall : (int_evt & clk_lvl));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      clk_lvl <= 1'b0;
    end else begin
      pin_q <= pin_s;
      if (mode_on && int_evt) clk_lvl <= ~clk_lvl;
    end
  end

  // R11: the internal level moves only on counted internal edges
  a_r11_lvl_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_pin && (edge_rise || edge_fall)) |=> (clk_lvl != $past(clk_lvl)));
  a_r11_lvl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(edge_rise || edge_fall) |=> $stable(clk_lvl));
endmodule

// File: rtl/syncser_counter.sv
module syncser_counter #(
  parameter int EDGES = 16,
  localparam int CW = $clog2(EDGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          edge_any,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_val,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic          flag,
  output logic          wrap
);
  localparam logic [CW-1:0] LAST = CW'(EDGES - 1);

  assign wrap = edge_any & ~wr_en & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_en)         cnt <= wr_val;
      else if (edge_any) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      if (wrap)          flag <= 1'b1;
      else if (clr)      flag <= 1'b0;
    end
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_any && !wr_en && cnt != LAST) |=> (cnt == CW'($past(cnt) + 1'b1)));
  a_r3_wrap_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_any && !wr_en && cnt == LAST) |=> (flag && cnt == '0));
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_any && !wr_en) |=> $stable(cnt));
endmodule

// File: rtl/syncser_shifter.sv
module syncser_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         edge_rise,
  input  logic         edge_fall,
  input  logic         din,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  input  logic         wrap,
  output logic [W-1:0] sr,
  output logic [W-1:0] bufq
);
  logic         smp;
  logic [W-1:0] sr_next;

  always_comb begin
    sr_next = sr;
    if (wr_en)          sr_next = wr_val;
    else if (edge_fall) sr_next = {sr[W-2:0], smp};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      smp  <= 1'b0;
      bufq <= '0;
    end else begin
      sr <= sr_next;
      if (edge_rise) smp  <= din;
      if (wrap)      bufq <= sr_next;
    end
  end

  a_r2_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (sr == $past(wr_val)));
  a_r4_shift_left: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_fall && !wr_en) |=> (sr[W-1:1] == $past(sr[W-2:0])));
  a_r8_buf_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(bufq));
endmodule

// File: rtl/syncser_twoctl.sv
module syncser_twoctl (
  input  logic clk,
  input  logic rst_n,
  input  logic is_two,
  input  logic sda_s,
  input  logic scl_s,
  input  logic clr_start,
  input  logic ovf_flag,
  output logic flag_start,
  output logic hold
);
  logic sda_q, start_det, need;

  assign start_det = is_two & sda_q & ~sda_s & scl_s;
  assign need      = is_two & (flag_start | ovf_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q      <= 1'b1;
      flag_start <= 1'b0;
      hold       <= 1'b0;
    end else begin
      sda_q <= sda_s;
      if (start_det)      flag_start <= 1'b1;
      else if (clr_start) flag_start <= 1'b0;
      if (!need)          hold <= 1'b0;
      else if (!scl_s)    hold <= 1'b1;
    end
  end

  a_r9_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_start) |-> $past(is_two && scl_s));
  a_r10_hold_cause: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> $past(is_two && (flag_start || ovf_flag)));
endmodule

// File: rtl/syncser_engine.sv
module syncser_engine
  import syncser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_wire_mode,
  input  logic [1:0]        cfg_clk_src,
  input  logic              cfg_master,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] buf_data,
  input  logic              wr_cnt_en,
  input  logic [CNT_W-1:0]  wr_cnt,
  output logic [CNT_W-1:0]  cnt_out,
  input  logic              soft_strobe,
  input  logic              tmr_match,
  input  logic              clr_start,
  input  logic              clr_ovf,
  output logic              flag_start,
  output logic              flag_ovf,
  input  logic              sck_in,
  output logic              sck_out,
  input  logic              di_in,
  output logic              do_out,
  input  logic              scl_in,
  output logic              scl_oe,
  input  logic              sda_in,
  output logic              sda_oe
);
  logic mode_three, mode_two, mode_on;
  logic [3:0] pins_s;
  logic scl_s, sda_s, sck_s, di_s;
  logic e_rise, e_fall, lvl, wrap, hold;
  clk_src_e src;

  assign mode_three = (cfg_wire_mode == WM_THREE);
  assign mode_two   = (cfg_wire_mode == WM_TWO);
  assign mode_on    = mode_three | mode_two;
  assign src        = clk_src_e'(cfg_clk_src);

  syncser_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({scl_in, sda_in, sck_in, di_in}), .q(pins_s)
  );
  assign {scl_s, sda_s, sck_s, di_s} = pins_s;

  syncser_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .mode_on(mode_on), .is_two(mode_two), .src(src),
    .soft_stb(soft_strobe), .tmr_stb(tmr_match), .sck_s(sck_s), .scl_s(scl_s),
    .edge_rise(e_rise), .edge_fall(e_fall), .clk_lvl(lvl)
  );

  syncser_counter #(.EDGES(2 * DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .edge_any(e_rise | e_fall),
    .wr_en(wr_cnt_en), .wr_val(wr_cnt), .clr(clr_ovf),
    .cnt(cnt_out), .flag(flag_ovf), .wrap(wrap)
  );

  syncser_shifter #(.W(DATA_W)) u_shf (
    .clk(clk), .rst_n(rst_n), .edge_rise(e_rise), .edge_fall(e_fall),
    .din(mode_two ? sda_s : di_s), .wr_en(wr_data_en), .wr_val(wr_data),
    .wrap(wrap), .sr(rd_data), .bufq(buf_data)
  );

  syncser_twoctl u_two (
    .clk(clk), .rst_n(rst_n), .is_two(mode_two), .sda_s(sda_s), .scl_s(scl_s),
    .clr_start(clr_start), .ovf_flag(flag_ovf), .flag_start(flag_start), .hold(hold)
  );

  assign do_out  = mode_three & rd_data[DATA_W-1];
  assign sda_oe  = mode_two & ~rd_data[DATA_W-1];
  assign sck_out = mode_three & cfg_master & lvl;
  assign scl_oe  = mode_two & (hold | (cfg_master & (src != CS_PIN) & ~lvl));

  a_r5_one_pin: assert property (@(posedge clk) disable iff (!rst_n)
    !(do_out && sda_oe));
  a_r7_off_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_on && !wr_cnt_en) |=> $stable(cnt_out));
endmodule

// File: tb/syncser_engine_tb_top.sv
module syncser_engine_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_wire_mode = 2'd0, cfg_clk_src = 2'd0;
  logic cfg_master = 1'b0;
  logic wr_data_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data, buf_data;
  logic wr_cnt_en = 1'b0;
  logic [3:0] wr_cnt = 4'd0, cnt_out;
  logic soft_strobe = 1'b0, tmr_match = 1'b0, clr_start = 1'b0, clr_ovf = 1'b0;
  logic flag_start, flag_ovf;
  logic sck_in = 1'b0, di_in = 1'b0, sck_out, do_out;
  logic scl_tb = 1'b1, sda_tb = 1'b1;
  logic scl_oe, sda_oe, scl_line, sda_line;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  assign scl_line = scl_tb & ~scl_oe;
  assign sda_line = sda_tb & ~sda_oe;

  always #2 clk = ~clk;

  syncser_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wire_mode(cfg_wire_mode), .cfg_clk_src(cfg_clk_src),
    .cfg_master(cfg_master), .wr_data_en(wr_data_en), .wr_data(wr_data),
    .rd_data(rd_data), .buf_data(buf_data), .wr_cnt_en(wr_cnt_en), .wr_cnt(wr_cnt),
    .cnt_out(cnt_out), .soft_strobe(soft_strobe), .tmr_match(tmr_match),
    .clr_start(clr_start), .clr_ovf(clr_ovf), .flag_start(flag_start),
    .flag_ovf(flag_ovf), .sck_in(sck_in), .sck_out(sck_out), .di_in(di_in),
    .do_out(do_out), .scl_in(scl_line), .scl_oe(scl_oe), .sda_in(sda_line),
    .sda_oe(sda_oe)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] m, input logic [1:0] s, input logic ms);
    @(negedge clk);
    cfg_wire_mode = m; cfg_clk_src = s; cfg_master = ms;
  endtask

  task automatic pulse_stb();
    @(negedge clk); soft_strobe = 1'b1;
    @(negedge clk); soft_strobe = 1'b0;
  endtask

  task automatic pulse_tmr();
    @(negedge clk); tmr_match = 1'b1;
    @(negedge clk); tmr_match = 1'b0;
  endtask

  task automatic write_sr_cnt(input logic [7:0] d, input logic we_c, input logic [3:0] c);
    @(negedge clk); wr_data_en = 1'b1; wr_data = d; wr_cnt_en = we_c; wr_cnt = c;
    @(negedge clk); wr_data_en = 1'b0; wr_cnt_en = 1'b0;
  endtask

  task automatic write_cnt(input logic [3:0] c);
    @(negedge clk); wr_cnt_en = 1'b1; wr_cnt = c;
    @(negedge clk); wr_cnt_en = 1'b0;
  endtask

  task automatic clear_flags(input logic s, input logic o);
    @(negedge clk); clr_start = s; clr_ovf = o;
    @(negedge clk); clr_start = 1'b0; clr_ovf = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // R1
  task automatic t_reset();
    @(negedge clk);
    chk("R1", "rd_data", rd_data, 0);
    chk("R1", "buf_data", buf_data, 0);
    chk("R1", "cnt", cnt_out, 0);
    chk("R1", "flag_ovf", flag_ovf, 0);
    chk("R1", "flag_start", flag_start, 0);
    chk("R1", "do_out", do_out, 0);
    chk("R1", "sck_out", sck_out, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "scl_oe", scl_oe, 0);
  endtask

  // R2: write, and write beating a shift edge
  task automatic t_write();
    set_cfg(2'd1, 2'd0, 1'b0);
    write_sr_cnt(8'h3C, 1'b0, 4'd0);
    chk("R2", "rd after write", rd_data, 8'h3C);
    pulse_stb();
    @(negedge clk); wr_data_en = 1'b1; wr_data = 8'h5A; soft_strobe = 1'b1;
    @(negedge clk); wr_data_en = 1'b0; soft_strobe = 1'b0;
    chk("R2", "write wins over shift", rd_data, 8'h5A);
    chk("R3", "two edges counted", cnt_out, 2);
  endtask

  // R3 R4 R5 R8 R11: full three-wire byte with the software strobe
  task automatic t_spi_byte();
    logic [7:0] tx = 8'hA5, rx = 8'h3C;
    set_cfg(2'd1, 2'd0, 1'b1);
    write_sr_cnt(tx, 1'b1, 4'd0);
    for (int i = 7; i >= 0; i--) begin
      di_in = rx[i];
      wait_n(3);
      chk("R5", "do_out bit", do_out, tx[i]);
      chk("R5", "sda_oe idle in three-wire", sda_oe, 0);
      pulse_stb();
      chk("R11", "sck_out high", sck_out, 1);
      pulse_stb();
      chk("R11", "sck_out low", sck_out, 0);
      chk("R3", "count", cnt_out, (2 * (8 - i)) % 16);
    end
    chk("R4", "received byte", rd_data, rx);
    chk("R8", "buffer byte", buf_data, rx);
    chk("R3", "overflow set", flag_ovf, 1);
    write_sr_cnt(8'h00, 1'b0, 4'd0);
    chk("R8", "buffer kept after write", buf_data, rx);
    clear_flags(1'b0, 1'b1);
    chk("R3", "overflow cleared", flag_ovf, 0);
  endtask

  // R3 R6 R7 R11: sources, mode off, set beats clear
  task automatic t_counter();
    set_cfg(2'd1, 2'd1, 1'b1);
    write_cnt(4'd0);
    pulse_stb();
    chk("R6", "strobe ignored on timer source", cnt_out, 0);
    pulse_tmr();
    chk("R11", "sck_out follows timer", sck_out, 1);
    pulse_tmr(); pulse_tmr(); pulse_tmr();
    chk("R6", "timer pulses counted", cnt_out, 4);
    set_cfg(2'd1, 2'd2, 1'b0);
    wait_n(2);
    sck_in = 1'b1; wait_n(4);
    chk("R6", "pin rise counted", cnt_out, 5);
    sck_in = 1'b0; wait_n(4);
    chk("R6", "pin fall counted", cnt_out, 6);
    pulse_tmr();
    chk("R6", "timer ignored on pin source", cnt_out, 6);
    set_cfg(2'd0, 2'd2, 1'b0);
    sck_in = 1'b1; wait_n(4);
    sck_in = 1'b0; wait_n(4);
    set_cfg(2'd0, 2'd0, 1'b0);
    pulse_stb();
    chk("R7", "no count when off", cnt_out, 6);
    chk("R7", "no flag when off", flag_ovf, 0);
    chk("R7", "rd unchanged when off", rd_data, 8'h00);
    set_cfg(2'd1, 2'd0, 1'b0);
    write_cnt(4'd15);
    @(negedge clk); soft_strobe = 1'b1; clr_ovf = 1'b1;
    @(negedge clk); soft_strobe = 1'b0; clr_ovf = 1'b0;
    chk("R3", "set beats clear", flag_ovf, 1);
    chk("R3", "wrap to zero", cnt_out, 0);
    pulse_stb();
    clear_flags(1'b0, 1'b1);
    set_cfg(2'd0, 2'd0, 1'b0);
  endtask

  // R5 R9 R10: steering, start detection and stretch after start
  task automatic t_two_start();
    set_cfg(2'd1, 2'd2, 1'b0);
    wait_n(3);
    sda_tb = 1'b0; wait_n(4);
    chk("R9", "no start in three-wire", flag_start, 0);
    sda_tb = 1'b1; wait_n(4);
    set_cfg(2'd2, 2'd2, 1'b0);
    write_sr_cnt(8'h00, 1'b0, 4'd0);
    chk("R5", "sda_oe low bit", sda_oe, 1);
    chk("R5", "do_out off in two-wire", do_out, 0);
    write_sr_cnt(8'h80, 1'b0, 4'd0);
    chk("R5", "sda_oe high bit", sda_oe, 0);
    write_sr_cnt(8'hFF, 1'b0, 4'd0);
    wait_n(3);
    sda_tb = 1'b0; wait_n(4);
    chk("R9", "start flagged", flag_start, 1);
    chk("R10", "no hold while scl high", scl_oe, 0);
    scl_tb = 1'b0; wait_n(4);
    chk("R10", "hold after scl low", scl_oe, 1);
    scl_tb = 1'b1; wait_n(4);
    chk("R10", "scl line stretched", scl_line, 0);
    clear_flags(1'b1, 1'b0);
    wait_n(2);
    chk("R10", "hold released", scl_oe, 0);
    chk("R9", "start cleared", flag_start, 0);
    sda_tb = 1'b1; wait_n(4);
    chk("R9", "stop does not flag", flag_start, 0);
  endtask

  // R4 R8 R10: two-wire slave byte on SCL edges, stretch on overflow
  task automatic t_two_byte();
    logic [7:0] rx = 8'h96;
    scl_tb = 1'b0; wait_n(4);
    write_sr_cnt(8'hFF, 1'b1, 4'd0);
    for (int i = 7; i >= 0; i--) begin
      sda_tb = rx[i]; wait_n(4);
      scl_tb = 1'b1; wait_n(4);
      scl_tb = 1'b0; wait_n(4);
    end
    chk("R4", "two-wire received byte", rd_data, rx);
    chk("R8", "two-wire buffer", buf_data, rx);
    chk("R3", "two-wire overflow", flag_ovf, 1);
    chk("R10", "hold after overflow", scl_oe, 1);
    scl_tb = 1'b1; sda_tb = 1'b1;
    clear_flags(1'b0, 1'b1);
    wait_n(2);
    chk("R10", "hold released after clear", scl_oe, 0);
  endtask

  // R11: two-wire master clock drive from the internal level
  task automatic t_two_master();
    set_cfg(2'd2, 2'd0, 1'b1);
    @(negedge clk);
    chk("R11", "scl pulled at low level", scl_oe, 1);
    pulse_stb();
    chk("R11", "scl released at high level", scl_oe, 0);
    pulse_stb();
    chk("R11", "scl pulled again", scl_oe, 1);
    set_cfg(2'd0, 2'd0, 1'b0);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_spi_byte();
    t_counter();
    t_two_start();
    t_two_byte();
    t_two_master();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end
endmodule